// File: doc/BRIEF.md
# Pixel Port Multiplex Serializer

This block takes one 64-bit word from a wide pixel bus and plays it out as a run of narrower pixels, one per pixel-clock beat. The pixel depth decides how many pixels the word holds: eight 8-bit pixels, four 16-bit pixels or two 32-bit pixels. The pixel at the lowest-numbered bus bits always leaves first. A byte-order control can reinterpret the bus as big-endian before the word is split into pixels.

The load and the shift both run in the pixel-clock domain. The loader raises a one-cycle strobe together with the word, the depth code and the byte-order bit. The serializer latches all three on that edge, so later changes to depth or byte order wait for the next strobe. Each pixel is presented on a 32-bit output with its upper bits cleared, and a valid flag marks it. If a new strobe arrives while the current word still has pixels left to send, the unsent pixels are dropped, the new word starts at once and an overrun flag is raised.

Control is a two-state machine. IDLE waits for a strobe, and the transition START takes it to SHIFT. SHIFT sends one pixel per beat and has four transitions. ADVANCE moves to the next pixel. DRAIN returns to IDLE after the final pixel when no strobe is present. RELOAD stays in SHIFT when a strobe lands on the final pixel. OVERRUN stays in SHIFT when a strobe lands on an earlier pixel.

Top module: `pix_mux_serializer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pix_valid_o, overrun_o and every bit of pix_o are 0.
- R2: A strobe on load_i at a clock edge makes pix_valid_o high in the cycle that follows, and pix_o in that cycle carries the first pixel of the new word.
- R3: Depth code 0 (8-bit) with byte order 0 sends bus bytes [7:0], [15:8] and so on up to [63:56] on eight consecutive beats in pix_o[7:0]. After the eighth beat, pix_valid_o falls unless another strobe is present.
- R4: Depth code 1 (16-bit) with byte order 0 sends bus bits [15:0], [31:16], [47:32] and [63:48] on four beats in pix_o[15:0], with pix_o[31:16] at 0.
- R5: Depth code 2 (32-bit) with byte order 0 sends bus bits [31:0] and then [63:32] on two beats. Depth code 3 behaves exactly like code 2.
- R6: With big_end_i = 1 at depth 16 or 32, each pixel still comes from the same bus bits, but its bytes are reversed: the byte at the pixel's lowest bus position lands in the pixel's most significant byte.
- R7: With big_end_i = 1 at depth 8, bytes leave in the order 3, 2, 1, 0, 7, 6, 5, 4, where byte k is bus bits [8k+7:8k].
- R8: Changes on depth_i, big_end_i and bus_i without a strobe do not alter the pixels of the word in flight.
- R9: A strobe that arrives in the cycle showing the last pixel of a word starts the new word on the next beat with no gap, and overrun_o stays 0.
- R10: A strobe that arrives while earlier pixels of a word are still pending raises overrun_o for exactly the next cycle. That cycle shows the new word's first pixel, and the dropped pixels never appear.
- R11: Whenever pix_valid_o is 0, pix_o and overrun_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | One-cycle strobe that latches bus_i, depth_i and big_end_i |
| bus_i | input | 64 | Wide pixel word |
| depth_i | input | 2 | Pixel depth: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| big_end_i | input | 1 | 1 = big-endian byte interpretation |
| pix_o | output | 32 | Current pixel, zero-extended |
| pix_valid_o | output | 1 | pix_o holds a pixel this beat |
| overrun_o | output | 1 | A strobe dropped unsent pixels of the previous word |

## Verification
A new strobe and the beat that finishes a word can land in the same cycle. That cycle must resolve as RELOAD: the next word follows with no gap and no overrun. A strobe that lands one beat earlier must resolve as OVERRUN instead. The bench drives both cases at every depth. It times each strobe from its own queue of pending pixels, lining up first with the last queued pixel and then with a pixel that still has others behind it. On every clock it compares pix_o, pix_valid_o and overrun_o against the queue, so a gap, a missing flag or a stale pixel leaking through is caught in the exact cycle where it appears.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } state_e;

    localparam logic [1:0] DEPTH_8  = 2'd0;
    localparam logic [1:0] DEPTH_16 = 2'd1;
    localparam logic [1:0] DEPTH_32 = 2'd2;

    // pixels held by one bus word for a given depth code
    function automatic int unsigned ratio_of(input logic [1:0] depth, input int unsigned bus_w);
        case (depth)
            DEPTH_8:  return bus_w / 8;
            DEPTH_16: return bus_w / 16;
            default:  return bus_w / 32;
        endcase
    endfunction

endpackage

// File: rtl/pms_reorder.sv
module pms_reorder #(
    parameter int BUS_W = 64
) (
    input  logic [BUS_W-1:0] word_i,
    input  logic [1:0]       depth_i,
    input  logic             big_i,
    output logic [BUS_W-1:0] word_o
);
    localparam int NBYTES = BUS_W / 8;

    // per byte lane: pick the source lane for each endian variant
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        localparam int SRC_PAIR = (b / 2) * 2 + (1 - (b % 2));
        localparam int SRC_QUAD = (b / 4) * 4 + (3 - (b % 4));
        always_comb begin
            if (!big_i) begin
                word_o[b*8 +: 8] = word_i[b*8 +: 8];
            end else if (depth_i == pms_pkg::DEPTH_16) begin
                word_o[b*8 +: 8] = word_i[SRC_PAIR*8 +: 8];
            end else begin
                // 8-bit: pixel order reversed per 32-bit half; 32-bit: bytes reversed per pixel
                word_o[b*8 +: 8] = word_i[SRC_QUAD*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl #(
    parameter int BUS_W = 64,
    localparam int MAX_RATIO = BUS_W / 8,
    localparam int IDX_W = $clog2(MAX_RATIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W:0]   ratio_i,
    output logic             valid_o,
    output logic             capture_o,
    output logic             overrun_o,
    output logic [IDX_W-1:0] idx_o
);
    import pms_pkg::*;

    state_e           st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W:0]   ratio_q, ratio_d;
    logic             ovr_q, ovr_d;
    logic [IDX_W:0]   last_idx;
    logic             at_last;

    assign last_idx = ratio_q - 1'b1;
    assign at_last  = ({1'b0, idx_q} == last_idx);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            ratio_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            idx_q   <= idx_d;
            ratio_q <= ratio_d;
            ovr_q   <= ovr_d;
        end
    end

    // transitions
    always_comb begin
        st_d    = st_q;
        idx_d   = idx_q;
        ratio_d = ratio_q;
        ovr_d   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (load_i) begin            // START
                    st_d    = ST_SHIFT;
                    idx_d   = '0;
                    ratio_d = ratio_i;
                end
            end
            ST_SHIFT: begin
                if (load_i) begin            // RELOAD or OVERRUN
                    idx_d   = '0;
                    ratio_d = ratio_i;
                    ovr_d   = !at_last;
                end else if (at_last) begin  // DRAIN
                    st_d  = ST_IDLE;
                    idx_d = '0;
                end else begin               // ADVANCE
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        valid_o   = (st_q == ST_SHIFT);
        capture_o = load_i;
        overrun_o = ovr_q;
        idx_o     = idx_q;
    end

endmodule

// File: rtl/pms_slice.sv
module pms_slice #(
    parameter int BUS_W = 64,
    parameter int PIX_W = 32,
    localparam int IDX_W = $clog2(BUS_W / 8)
) (
    input  logic [BUS_W-1:0] word_i,
    input  logic [1:0]       depth_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [PIX_W-1:0] pix_o
);
    always_comb begin
        int ix;
        ix    = int'(idx_i);
        pix_o = '0;
        case (depth_i)
            pms_pkg::DEPTH_8:  pix_o[7:0]  = word_i[(ix % (BUS_W/8))*8 +: 8];
            pms_pkg::DEPTH_16: pix_o[15:0] = word_i[(ix % (BUS_W/16))*16 +: 16];
            default:           pix_o[31:0] = word_i[(ix % (BUS_W/32))*32 +: 32];
        endcase
    end

endmodule

// File: rtl/pix_mux_serializer.sv
module pix_mux_serializer #(
    parameter int BUS_W = 64,
    parameter int PIX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic [1:0]       depth_i,
    input  logic             big_end_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             pix_valid_o,
    output logic             overrun_o
);
    localparam int IDX_W = $clog2(BUS_W / 8);

    logic [BUS_W-1:0] ordered;
    logic [BUS_W-1:0] word_q;
    logic [1:0]       depth_q;
    logic [IDX_W:0]   ratio_in;
    logic             valid;
    logic             capture;
    logic [IDX_W-1:0] idx;
    logic [PIX_W-1:0] slice_pix;

    assign ratio_in = (IDX_W+1)'(pms_pkg::ratio_of(depth_i, BUS_W));

    pms_reorder #(.BUS_W(BUS_W)) i_reorder (
        .word_i  (bus_i),
        .depth_i (depth_i),
        .big_i   (big_end_i),
        .word_o  (ordered)
    );

    pms_ctrl #(.BUS_W(BUS_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .ratio_i   (ratio_in),
        .valid_o   (valid),
        .capture_o (capture),
        .overrun_o (overrun_o),
        .idx_o     (idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            depth_q <= pms_pkg::DEPTH_8;
        end else if (capture) begin
            word_q  <= ordered;
            depth_q <= depth_i;
        end
    end

    pms_slice #(.BUS_W(BUS_W), .PIX_W(PIX_W)) i_slice (
        .word_i  (word_q),
        .depth_i (depth_q),
        .idx_i   (idx),
        .pix_o   (slice_pix)
    );

    assign pix_valid_o = valid;
    assign pix_o       = valid ? slice_pix : '0;

endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
    parameter int BUS_W = 64,
    parameter int PIX_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [1:0]       depth_i,
    input logic [PIX_W-1:0] pix_o,
    input logic             pix_valid_o,
    input logic             overrun_o
);
    int unsigned rem;

    // beats still owed after the current one
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= 0;
        else if (load_i)
            rem <= pms_pkg::ratio_of(depth_i, BUS_W) - 1;
        else if (rem != 0)
            rem <= rem - 1;
    end

    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pix_valid_o);

    a_r3_drain_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && rem == 0 && !load_i) |=> !pix_valid_o);

    a_r3_beats_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && rem != 0 && !load_i) |=> pix_valid_o);

    a_r10_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && pix_valid_o && rem != 0) |=> overrun_o);

    a_r9_no_false_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (!pix_valid_o || rem == 0)) |=> !overrun_o);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_o |-> (pix_o == '0 && !overrun_o));

endmodule

bind pix_mux_serializer pms_checker #(.BUS_W(BUS_W), .PIX_W(PIX_W)) i_pms_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .depth_i     (depth_i),
    .pix_o       (pix_o),
    .pix_valid_o (pix_valid_o),
    .overrun_o   (overrun_o)
);

// File: tb/test_pix_mux_serializer.sv
`timescale 1ns/1ps
module test_pix_mux_serializer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_i;
    logic [63:0] bus_i;
    logic [1:0]  depth_i;
    logic        big_end_i;
    logic [31:0] pix_o;
    logic        pix_valid_o;
    logic        overrun_o;

    always #2 clk = ~clk;

    pix_mux_serializer i_pix_mux_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .bus_i       (bus_i),
        .depth_i     (depth_i),
        .big_end_i   (big_end_i),
        .pix_o       (pix_o),
        .pix_valid_o (pix_valid_o),
        .overrun_o   (overrun_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    string       cur_req = "R1";
    logic [31:0] q[$];
    logic        exp_ovr = 1'b0;

    task automatic chk(input string req, input string what, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected pixels of one word, derived from the requirements
    function automatic void push_word(input logic [63:0] w, input logic [1:0] d, input logic be);
        int n  = (d == 2'd0) ? 8 : (d == 2'd1) ? 4 : 2;
        int nb = 8 / n;
        for (int k = 0; k < n; k++) begin
            logic [31:0] p = '0;
            for (int j = 0; j < nb; j++) begin
                int src;
                if (!be)          src = k * nb + j;
                else if (nb == 1) src = (k / 4) * 4 + 3 - (k % 4);
                else              src = k * nb + (nb - 1 - j);
                p[j*8 +: 8] = w[src*8 +: 8];
            end
            q.push_back(p);
        end
    endfunction

    task automatic tick(input logic ld, input logic [63:0] w, input logic [1:0] d, input logic be);
        logic        ev;
        logic [31:0] ep;
        load_i = ld; bus_i = w; depth_i = d; big_end_i = be;
        @(posedge clk);
        if (q.size() > 0) void'(q.pop_front());
        exp_ovr = 1'b0;
        if (ld) begin
            exp_ovr = (q.size() > 0);
            q.delete();
            push_word(w, d, be);
        end
        @(negedge clk);
        ev = (q.size() > 0);
        ep = ev ? q[0] : 32'h0;
        chk(cur_req, "valid", pix_valid_o == ev, 64'(pix_valid_o), 64'(ev));
        chk(cur_req, "pixel", pix_o == ep, 64'(pix_o), 64'(ep));
        chk(cur_req, "overrun", overrun_o == exp_ovr, 64'(overrun_o), 64'(exp_ovr));
        load_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 64'hDEAD_BEEF_0BAD_F00D, 2'd2, 1'b1);
    endtask

    task automatic run_word(input logic [63:0] w, input logic [1:0] d, input logic be);
        tick(1'b1, w, d, be);
        while (q.size() > 0) tick(1'b0, ~w, ~d, ~be);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load_i = 1'b0; bus_i = '0; depth_i = 2'd0; big_end_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", "reset outputs", pix_valid_o == 0 && overrun_o == 0 && pix_o == 0,
                {pix_o, 30'd0, pix_valid_o, overrun_o}, 64'h0);
        end
        rst_n = 1'b1;
        cur_req = "R1"; idle(1);

        cur_req = "R2"; tick(1'b1, 64'h7766_5544_3322_1100, 2'd0, 1'b0);
        chk("R2", "first pixel", pix_o == 32'h00 && pix_valid_o, 64'(pix_o), 64'h0);
        cur_req = "R3"; while (q.size() > 0) tick(1'b0, '0, 2'd1, 1'b1);
        cur_req = "R11"; idle(3);

        cur_req = "R3"; run_word(64'hF0E1_D2C3_B4A5_9687, 2'd0, 1'b0);
        cur_req = "R4"; run_word(64'h0123_4567_89AB_CDEF, 2'd1, 1'b0);
        cur_req = "R5"; run_word(64'hCAFE_BABE_1234_5678, 2'd2, 1'b0);
        cur_req = "R5"; run_word(64'hA5A5_5A5A_0F0F_F0F0, 2'd3, 1'b0);
        cur_req = "R6"; run_word(64'h0123_4567_89AB_CDEF, 2'd1, 1'b1);
        cur_req = "R6"; run_word(64'h0123_4567_89AB_CDEF, 2'd2, 1'b1);
        cur_req = "R7"; run_word(64'h7766_5544_3322_1100, 2'd0, 1'b1);
        cur_req = "R11"; idle(2);

        cur_req = "R8";
        tick(1'b1, 64'h1111_2222_3333_4444, 2'd0, 1'b0);
        for (int i = 0; i < 7; i++) tick(1'b0, 64'(i) * 64'h0101_0101, 2'(i), i[0]);
        idle(1);

        // R9: strobe on the last beat at every depth
        cur_req = "R9";
        for (int d = 0; d < 3; d++) begin
            tick(1'b1, 64'h1020_3040_5060_7080 + 64'(d), 2'(d), 1'b0);
            while (q.size() > 1) tick(1'b0, '0, 2'd0, 1'b0);
            tick(1'b1, 64'h8877_6655_4433_2211 + 64'(d), 2'(d), 1'b1);
            chk("R9", "no overrun at seam", overrun_o == 0 && pix_valid_o,
                {62'd0, overrun_o, pix_valid_o}, 64'h1);
            while (q.size() > 0) tick(1'b0, '0, 2'd0, 1'b0);
        end
        idle(1);

        // R10: strobe while pixels remain
        cur_req = "R10";
        for (int d = 0; d < 3; d++) begin
            tick(1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 2'(d), 1'b0);
            while (q.size() > 2) tick(1'b0, '0, 2'd0, 1'b0);
            tick(1'b1, 64'h0F1E_2D3C_4B5A_6978 + 64'(d), 2'(d), d[0]);
            chk("R10", "overrun raised", overrun_o == 1, 64'(overrun_o), 64'h1);
            tick(1'b0, '0, 2'd0, 1'b0);
            chk("R10", "overrun one cycle", overrun_o == 0, 64'(overrun_o), 64'h0);
            while (q.size() > 0) tick(1'b0, '0, 2'd0, 1'b0);
        end
        tick(1'b1, 64'h1234_5678_9ABC_DEF0, 2'd0, 1'b0);
        tick(1'b1, 64'hFEDC_BA98_7654_3210, 2'd0, 1'b0);
        while (q.size() > 0) tick(1'b0, '0, 2'd0, 1'b0);
        cur_req = "R11"; idle(3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule